// File: doc/BRIEF.md
# Scan Ring Field Save/Restore Sequencer

This block is a control sequencer that protects a handful of bit fields in a long scan ring across an operation that would otherwise lose them. It talks to a scan controller through a small register port with four targets: a region/type select word, a 64-bit scan data window, a long-rotate command and a status word. In save mode it walks the ring to a fixed list of positions and keeps the masked contents of the window at each one in eight internal 64-bit slots. In restore mode it walks to the same positions and merges those kept bits back into whatever the ring now holds.

A known header word is placed in the window before the first rotate. After the last rotate the ring has gone round exactly once, so the header must read back unchanged. A mismatch is reported together with the word that was read. A programmable poll timeout keeps the sequencer from hanging on a scan controller that never reports completion.

The sequence only runs when two enable inputs are both high. Otherwise a start request finishes at once without touching the port.

Top module: `scan_ring_keeper`

## Requirements
- R1: A `start` pulse while idle is accepted. `busy` is high from the next cycle up to and including the cycle of `done`. `done` is high for exactly one cycle, and `busy` is low in the cycle after it.
- R2: Unless `preserve_boot` and `save_feature` are both high at start, `done` rises on the cycle after the start and no port request is made.
- R3: The port target encoding is: 0 = select, 1 = window, 2 = rotate, 3 = status. `reg_we`=1 marks a write. Read data is valid in the same cycle as the read request. The first access of a run writes 0x0C10000000000010 to target 0; this is bits 4, 5, 11 and 59 in MSB-0 numbering. The last access writes zero to target 0.
- R4: The second access writes 0xA5A5A5A5A5A5A5A5 to the window, before any rotate.
- R5: Nine rotate writes are issued, with counts 5039, 61, 564, 61, 248, 61, 248, 61 and 11528 in data bits [63:32] and bits [31:0] zero. Together they total 17871.
- R6: After each rotate the status word is read every cycle until bit 55 (bit 8 in MSB-0 numbering) is one. Only then is the window read.
- R7: The step mask is 0xE000000000000000 for steps 1, 3, 5 and 7, and 0xC1E061FFED5F0000 for steps 2, 4, 6 and 8. In save mode, steps 1 to 8 keep (mask AND window) in slot k-1 and write nothing to the window.
- R8: In restore mode, steps 1 to 8 read the window and then write ((window AND NOT mask) OR slot k-1) back to it.
- R9: At step 9 the window is compared with the header. On mismatch `err_header` is set and `bad_word` holds the word that was read.
- R10: After `poll_limit`+1 consecutive status reads with the ready bit clear, the run aborts. It sets `err_timeout`, skips the remaining steps, writes zero to target 0 and signals `done`.
- R11: `err_header`, `err_timeout` and `bad_word` keep their values until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse |
| mode | input | 1 | 0 = save, 1 = restore |
| preserve_boot | input | 1 | Memory-preserving reboot in progress |
| save_feature | input | 1 | Field save feature enabled |
| poll_limit | input | 16 | Allowed not-ready status reads per rotate |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| err_header | output | 1 | Header mismatch after full wrap |
| err_timeout | output | 1 | Status poll timeout |
| bad_word | output | 64 | Window value read at the failed header check |
| reg_req | output | 1 | Port access request |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | 2 | Port target |
| reg_wdata | output | 64 | Write data |
| reg_rdata | input | 64 | Read data, same cycle |

## Verification
The slots cannot be seen from the ports, so they are only observable through a later restore. The bench therefore runs a save on one ring image, changes the scan model's background pattern, and then restores. Every window write must combine the new image outside the mask with the old image inside it, at the position reached by the rotates. A header mismatch needs a ring that does not return intact after a full wrap. The scan model is made to corrupt the header word as it is stored. A timeout needs a controller that never reports ready, which the model provides through a hang switch.

// File: rtl/srk_pkg.sv
package srk_pkg;
  localparam int unsigned DW       = 64;
  localparam int unsigned STEPS    = 9;
  localparam int unsigned RDY_BIT  = 55;   // MSB-0 bit 8
  localparam logic [DW-1:0] SEL_WORD = 64'h0C10_0000_0000_0010;
  localparam logic [DW-1:0] HDR_WORD = 64'hA5A5_A5A5_A5A5_A5A5;

  typedef enum logic [1:0] {
    T_SEL  = 2'd0,
    T_WIN  = 2'd1,
    T_ROT  = 2'd2,
    T_STAT = 2'd3
  } srk_tgt_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_HDR, S_ROT, S_POLL, S_RDW, S_WRW, S_CLR, S_FIN
  } srk_state_e;

  // ring position reached after step k
  function automatic logic [31:0] srk_pos(input logic [3:0] k);
    case (k)
      4'd1:    return 32'd5039;
      4'd2:    return 32'd5100;
      4'd3:    return 32'd5664;
      4'd4:    return 32'd5725;
      4'd5:    return 32'd5973;
      4'd6:    return 32'd6034;
      4'd7:    return 32'd6282;
      4'd8:    return 32'd6343;
      4'd9:    return 32'd17871;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] srk_delta(input logic [3:0] k);
    return srk_pos(k) - srk_pos(k - 4'd1);
  endfunction

  function automatic logic [DW-1:0] srk_mask(input logic [3:0] k);
    if (k == 4'd0 || k >= 4'd9) return '0;
    return k[0] ? 64'hE000_0000_0000_0000 : 64'hC1E0_61FF_ED5F_0000;
  endfunction
endpackage

// File: rtl/srk_slot_bank.sv
module srk_slot_bank #(
  parameter int unsigned N  = 8,
  parameter int unsigned W  = 64,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] slot [N];

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot[i] <= '0;
      else if (wr_en && wr_idx == IW'(i)) slot[i] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];
endmodule

// File: rtl/srk_poll_timer.sv
module srk_poll_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         miss,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  assign expired = miss && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (miss && !expired) cnt <= cnt + 1'b1;
  end

  // R10
  poll_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !expired && !clear) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/scan_ring_keeper.sv
module scan_ring_keeper
  import srk_pkg::*;
#(
  parameter int unsigned POLL_W = 16,
  parameter int unsigned SLOTS  = 8,
  localparam int unsigned IW    = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic              preserve_boot,
  input  logic              save_feature,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              busy,
  output logic              done,
  output logic              err_header,
  output logic              err_timeout,
  output logic [DW-1:0]     bad_word,
  output logic              reg_req,
  output logic              reg_we,
  output logic [1:0]        reg_addr,
  output logic [DW-1:0]     reg_wdata,
  input  logic [DW-1:0]     reg_rdata
);
  srk_state_e    state;
  logic [3:0]    step;
  logic          restore_q;
  logic [DW-1:0] hold;
  logic [DW-1:0] slot_rd;

  // named internal events
  logic accept, poll_ok, poll_miss, poll_expired, last_step, slot_wr;
  assign accept    = (state == S_IDLE) && start;
  assign poll_ok   = (state == S_POLL) && reg_rdata[RDY_BIT];
  assign poll_miss = (state == S_POLL) && !reg_rdata[RDY_BIT];
  assign last_step = (step == 4'(STEPS));
  assign slot_wr   = (state == S_RDW) && !last_step && !restore_q;

  srk_poll_timer #(.W(POLL_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .clear(state != S_POLL), .miss(poll_miss),
    .limit(poll_limit), .expired(poll_expired)
  );

  srk_slot_bank #(.N(SLOTS), .W(DW)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .wr_en(slot_wr), .wr_idx(IW'(step - 4'd1)),
    .wr_data(srk_mask(step) & reg_rdata),
    .rd_idx(IW'(step - 4'd1)), .rd_data(slot_rd)
  );

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

  always_comb begin
    reg_req   = 1'b0;
    reg_we    = 1'b0;
    reg_addr  = T_SEL;
    reg_wdata = '0;
    case (state)
      S_SEL:  begin reg_req = 1'b1; reg_we = 1'b1; reg_wdata = SEL_WORD; end
      S_HDR:  begin reg_req = 1'b1; reg_we = 1'b1; reg_addr = T_WIN; reg_wdata = HDR_WORD; end
      S_ROT:  begin reg_req = 1'b1; reg_we = 1'b1; reg_addr = T_ROT;
                    reg_wdata = {srk_delta(step), 32'h0}; end
      S_POLL: begin reg_req = 1'b1; reg_addr = T_STAT; end
      S_RDW:  begin reg_req = 1'b1; reg_addr = T_WIN; end
      S_WRW:  begin reg_req = 1'b1; reg_we = 1'b1; reg_addr = T_WIN;
                    reg_wdata = (hold & ~srk_mask(step)) | slot_rd; end
      S_CLR:  begin reg_req = 1'b1; reg_we = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      step        <= 4'd0;
      restore_q   <= 1'b0;
      hold        <= '0;
      err_header  <= 1'b0;
      err_timeout <= 1'b0;
      bad_word    <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          err_header  <= 1'b0;
          err_timeout <= 1'b0;
          bad_word    <= '0;
          restore_q   <= mode;
          step        <= 4'd1;
          state       <= (preserve_boot && save_feature) ? S_SEL : S_FIN;
        end
        S_SEL:  state <= S_HDR;
        S_HDR:  state <= S_ROT;
        S_ROT:  state <= S_POLL;
        S_POLL: if (poll_ok) state <= S_RDW;
                else if (poll_expired) begin
                  err_timeout <= 1'b1;
                  state       <= S_CLR;
                end
        S_RDW: begin
          if (last_step) begin
            if (reg_rdata != HDR_WORD) begin
              err_header <= 1'b1;
              bad_word   <= reg_rdata;
            end
            state <= S_CLR;
          end else if (restore_q) begin
            hold  <= reg_rdata;
            state <= S_WRW;
          end else begin
            step  <= step + 4'd1;
            state <= S_ROT;
          end
        end
        S_WRW: begin
          step  <= step + 4'd1;
          state <= S_ROT;
        end
        S_CLR:   state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> busy);
  // R5
  rot_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == T_ROT) |-> (reg_wdata[31:0] == 32'h0));
  // R6
  win_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_we && reg_addr == T_WIN) |->
      $past(reg_req && reg_addr == T_STAT && reg_rdata[RDY_BIT]));
  // R10
  timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |->
      (reg_req && reg_we && reg_addr == T_SEL && reg_wdata == '0));
  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err_header) && $stable(bad_word));
endmodule

// File: tb/sim_scan_ring_keeper.sv
module sim_scan_ring_keeper;
  localparam int RING = 17871;
  localparam logic [63:0] SELW = 64'h0C10_0000_0000_0010;
  localparam logic [63:0] HDRW = 64'hA5A5_A5A5_A5A5_A5A5;
  localparam logic [63:0] MODD = 64'hE000_0000_0000_0000;
  localparam logic [63:0] MEVN = 64'hC1E0_61FF_ED5F_0000;

  logic clk = 0, rst_n = 0, start = 0, mode = 0;
  logic preserve_boot = 0, save_feature = 0;
  logic [15:0] poll_limit = 16'd50;
  logic busy, done, err_header, err_timeout;
  logic [63:0] bad_word;
  logic reg_req, reg_we;
  logic [1:0] reg_addr;
  logic [63:0] reg_wdata, reg_rdata;

  always #4 clk = ~clk;

  scan_ring_keeper u0 (.*);

  // scan controller model
  logic [63:0] seed = 64'h0, corrupt = 64'h0;
  int delay = 0;
  logic hang = 0;
  int pos, bcnt, nw, nmiss;
  logic [63:0] hdr_store;
  logic [1:0]  wl_addr [256];
  logic [63:0] wl_data [256];
  int          wl_pos  [256];
  logic ready;
  assign ready = !hang && (bcnt == 0);

  function automatic logic [63:0] pat(input int p);
    logic [31:0] a, b;
    a = 32'(p) * 32'h9E37_79B1;
    b = ~(32'(p) * 32'h85EB_CA6B);
    return {a, b};
  endfunction

  always_comb begin
    case (reg_addr)
      2'd1:    reg_rdata = (pos == 0) ? hdr_store : (pat(pos) ^ seed);
      2'd3:    reg_rdata = {8'h0, ready, 55'h0};
      default: reg_rdata = 64'h0;
    endcase
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      pos <= 0; bcnt <= 0; nw <= 0; nmiss <= 0; hdr_store <= 64'h0;
    end else begin
      if (bcnt > 0) bcnt <= bcnt - 1;
      if (reg_req && reg_we) begin
        wl_addr[nw % 256] <= reg_addr;
        wl_data[nw % 256] <= reg_wdata;
        wl_pos[nw % 256]  <= pos;
        nw <= nw + 1;
        if (reg_addr == 2'd1 && pos == 0) hdr_store <= reg_wdata ^ corrupt;
        if (reg_addr == 2'd2) begin
          pos  <= (pos + int'(reg_wdata[63:32])) % RING;
          bcnt <= delay;
        end
      end else if (reg_req && reg_addr == 2'd3 && !ready) nmiss <= nmiss + 1;
    end
  end

  int nchk = 0, nerr = 0;
  int offs [10] = '{0, 5039, 5100, 5664, 5725, 5973, 6034, 6282, 6343, 17871};
  logic [63:0] saved_seed;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mask_of(input int k);
    return (k % 2 == 1) ? MODD : MEVN;
  endfunction

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic launch(input logic m);
    start = 1; mode = m;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R1 busy after start", 64'(busy), 64'd1);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done == 1'b1, req, 64'(done), 64'd1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R1 done one cycle, busy drops", {done, busy}, 64'd0);
  endtask

  task automatic check_frame(input int b, input int n_exp, input string tag);
    chk(nw - b == n_exp, {tag, " write count"}, 64'(nw - b), 64'(n_exp));
    chk(wl_addr[b] == 2'd0 && wl_data[b] == SELW, "R3 first select word", wl_data[b], SELW);
    chk(wl_addr[b+1] == 2'd1 && wl_data[b+1] == HDRW, "R4 header first", wl_data[b+1], HDRW);
    chk(wl_addr[b+n_exp-1] == 2'd0 && wl_data[b+n_exp-1] == 64'h0, "R3 select cleared",
        wl_data[b+n_exp-1], 64'h0);
  endtask

  task automatic test_reset();
    chk(busy == 0 && done == 0 && err_header == 0 && err_timeout == 0 && reg_req == 0,
        "R1 reset state", {busy, done, err_header, err_timeout, reg_req}, 64'h0);
  endtask

  task automatic test_bypass(input logic pb, input logic sf);
    int b = nw;
    preserve_boot = pb; save_feature = sf;
    start = 1; mode = 0;
    @(negedge clk);
    start = 0;
    chk(done == 1'b1, "R2 bypass done next cycle", 64'(done), 64'd1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R2 bypass single pulse", {done, busy}, 64'd0);
    chk(nw == b, "R2 no port writes", 64'(nw - b), 64'd0);
  endtask

  task automatic test_save(input logic [63:0] s, input int d);
    int b = nw;
    preserve_boot = 1; save_feature = 1; seed = s; delay = d; saved_seed = s;
    launch(1'b0);
    wait_done("R1 save done");
    check_frame(b, 12, "R7 save");
    for (int k = 1; k <= 9; k++) begin
      logic [63:0] e;
      e = {32'(offs[k] - offs[k-1]), 32'h0};
      chk(wl_addr[b+1+k] == 2'd2 && wl_data[b+1+k] == e, "R5 rotate word", wl_data[b+1+k], e);
    end
    chk(err_header == 0 && err_timeout == 0, "R9 no error on intact ring",
        {err_header, err_timeout}, 64'h0);
  endtask

  task automatic test_restore(input logic [63:0] s);
    int b = nw;
    seed = s;
    launch(1'b1);
    wait_done("R1 restore done");
    check_frame(b, 20, "R8 restore");
    for (int k = 1; k <= 8; k++) begin
      int i;
      logic [63:0] e;
      i = b + 3 + 2*(k-1);
      e = ((pat(offs[k]) ^ s) & ~mask_of(k)) | (mask_of(k) & (pat(offs[k]) ^ saved_seed));
      chk(wl_addr[i] == 2'd1 && wl_data[i] == e, "R8 R7 merged window", wl_data[i], e);
      chk(wl_pos[i] == offs[k], "R5 position of write", 64'(wl_pos[i]), 64'(offs[k]));
      chk(wl_addr[i-1] == 2'd2, "R8 write follows rotate", 64'(wl_addr[i-1]), 64'd2);
    end
    chk(err_header == 0, "R9 restore header ok", 64'(err_header), 64'd0);
  endtask

  task automatic test_header_bad();
    corrupt = 64'h0000_0100_0000_0001;
    launch(1'b0);
    wait_done("R9 corrupt run done");
    chk(err_header == 1'b1, "R9 header error", 64'(err_header), 64'd1);
    chk(bad_word == (HDRW ^ corrupt), "R9 latched word", bad_word, HDRW ^ corrupt);
    chk(err_timeout == 1'b0, "R9 no timeout", 64'(err_timeout), 64'd0);
    repeat (3) @(negedge clk);
    chk(err_header == 1'b1 && bad_word == (HDRW ^ corrupt), "R11 error held", bad_word, HDRW ^ corrupt);
    corrupt = 64'h0;
    launch(1'b0);
    chk(err_header == 1'b0 && bad_word == 64'h0, "R11 cleared on start", bad_word, 64'h0);
    wait_done("R11 clean run done");
  endtask

  task automatic test_timeout();
    int b = nw;
    int m = nmiss;
    hang = 1; poll_limit = 16'd5;
    launch(1'b0);
    wait_done("R10 timeout done");
    chk(err_timeout == 1'b1 && err_header == 1'b0, "R10 timeout flag",
        {err_timeout, err_header}, 64'h2);
    chk(nmiss - m == 6, "R10 miss reads", 64'(nmiss - m), 64'd6);
    chk(nw - b == 4 && wl_data[nw-1] == 64'h0 && wl_addr[nw-1] == 2'd0,
        "R10 R3 select cleared after abort", 64'(nw - b), 64'd4);
    hang = 0;
  endtask

  task automatic test_slow_poll();
    int m = nmiss;
    poll_limit = 16'd50;
    do_reset();
    test_save(64'h1357_9BDF_0246_8ACE, 3);
    chk(nmiss - m == 27, "R6 polled until ready", 64'(nmiss - m), 64'd27);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    nerr++;
    nchk++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    do_reset();
    test_reset();
    test_bypass(1'b0, 1'b1);
    test_bypass(1'b1, 1'b0);
    test_save(64'h0, 0);
    test_restore(64'hFFFF_0000_FFFF_0000);
    test_slow_poll();
    test_restore(64'h0F0F_F0F0_3C3C_C3C3);
    test_header_bad();
    test_timeout();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule